// File: doc/BRIEF.md
# Phase Comparison Coincidence Trip Logic

This block is the digital comparer of a phase-comparison line-protection relay. It takes a squared local-current polarity bit, which is high during the positive half cycle, and the output of the pilot-channel receiver. It also takes two overcurrent detector flags: a sensitive low-set flag and a less sensitive high-set flag. From these it produces a transmitter keying level and a latched trip output. All four field inputs are asynchronous. Each passes through a two-flop synchronizer before any logic uses it.

One comparer serves both pilot philosophies. In tripping mode, a received signal during the local positive half cycle permits tripping. In blocking mode, the absence of a received signal during the local positive half cycle permits tripping. Configuration pins set three things: receiver polarity, transmitter polarity and a coincidence threshold. The block samples these pins only while the synchronous reset is held, so they can be changed freely at other times without effect. The low-set detector keys the channel. The high-set detector supervises the trip path. A coincidence counter must see the supervised comparison hold on consecutive clocks before trip is latched.

The block has no streaming data path. Every pin is a plain level-sensitive control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `pcc_trip_logic`

## Requirements
- R1: In tripping mode (cfg_block_i = 0), the comparison is true only when the effective receiver bit is 1 and the synchronized polarity bit is 1.
- R2: In blocking mode (cfg_block_i = 1), the comparison is true only when the effective receiver bit is 0 and the synchronized polarity bit is 1.
- R3: The effective receiver bit is rx_raw_i XOR cfg_rx_inv_i. A value of 1 on cfg_rx_inv_i means the receiver drives low when a signal is present.
- R4: tx_key_o equals the keying request XOR cfg_tx_inv_i. A value of 1 on cfg_tx_inv_i means the channel is keyed by a low level.
- R5: The keying request is 1 exactly when the synchronized polarity bit and the synchronized low-set flag are both 1. An input change appears on tx_key_o after the third rising clock edge.
- R6: Trip needs the synchronized high-set flag. With only the low-set flag asserted, trip never asserts, whatever the mode or receiver input.
- R7: The counter advances on each clock where both the comparison and the high-set flag are true, and it clears on any clock where either is false. Trip sets on the Nth consecutive qualifying edge, which is N+2 rising edges after the inputs change. A threshold of 0 behaves as 1.
- R8: Once set, trip_o stays 1 until rst_i is sampled high, even after the inputs drop.
- R9: Mode, both polarities and the threshold are captured only on edges where rst_i is 1. Changing them later has no effect.
- R10: While rst_i is held, trip_o is 0 and tx_key_o sits at the unkeyed level, which equals cfg_tx_inv_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; configuration is captured while it is high |
| cfg_block_i | input | 1 | 0 selects tripping mode, 1 selects blocking mode |
| cfg_rx_inv_i | input | 1 | 1 means the receiver output is active-low |
| cfg_tx_inv_i | input | 1 | 1 means the transmitter is keyed by a low level |
| cfg_thr_i | input | CNT_W | Coincidence threshold in clock cycles |
| cur_pos_i | input | 1 | Squared local current, high in the positive half cycle (asynchronous) |
| rx_raw_i | input | 1 | Pilot receiver output (asynchronous) |
| det_low_i | input | 1 | Low-set overcurrent flag (asynchronous) |
| det_high_i | input | 1 | High-set overcurrent flag (asynchronous) |
| tx_key_o | output | 1 | Transmitter keying level |
| trip_o | output | 1 | Latched trip |

## Verification
The bench first runs through every combination of mode and receiver polarity, so that a comparer with the sense of blocking swapped, or with a missing inverter, trips on the wrong vectors. It then interrupts the coincidence one cycle short of the threshold. A counter that holds its count instead of clearing would trip early, and an off-by-one compare would trip one edge too soon or too late around N+2. It also drops the inputs after a trip to catch a trip output that is not latched. Finally, it changes the configuration after reset is released and checks that the captured mode still governs, which exposes logic that reads the configuration pins live.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic {
    PCC_MODE_PERMIT = 1'b0,
    PCC_MODE_BLOCK  = 1'b1
  } pcc_mode_e;

  typedef struct packed {
    pcc_mode_e mode;
    logic      rx_inv;
    logic      tx_inv;
  } pcc_cfg_t;

  localparam int PCC_SYNC_STAGES = 2;
  localparam int PCC_FIELD_BITS  = 4;
endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[s] <= '0;
          else       stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[s] <= '0;
          else       stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcc_cfg_reg.sv
module pcc_cfg_reg
  import pcc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  pcc_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] thr_i,
  output pcc_cfg_t         cfg_o,
  output logic [CNT_W-1:0] thr_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_o <= cfg_i;
      thr_o <= thr_i;
    end
  end
endmodule

// File: rtl/pcc_comparer.sv
module pcc_comparer
  import pcc_pkg::*;
(
  input  pcc_cfg_t cfg_i,
  input  logic     pos_i,
  input  logic     rx_i,
  input  logic     low_i,
  input  logic     high_i,
  output logic     qual_o,
  output logic     key_lvl_o
);
  logic rx_eff;
  logic coinc;

  always_comb begin
    rx_eff = rx_i ^ cfg_i.rx_inv;
    unique case (cfg_i.mode)
      PCC_MODE_BLOCK:  coinc = pos_i & ~rx_eff;
      default:         coinc = pos_i &  rx_eff;
    endcase
    qual_o    = coinc & high_i;
    key_lvl_o = (pos_i & low_i) ^ cfg_i.tx_inv;
  end
endmodule

// File: rtl/pcc_integrator.sv
module pcc_integrator #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             qual_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0] cnt_inc;
  assign cnt_inc = {1'b0, cnt_o} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o  <= '0;
      trip_o <= 1'b0;
    end else if (qual_i) begin
      if (cnt_o != CNT_MAX) cnt_o <= cnt_inc[CNT_W-1:0];
      if (cnt_inc >= {1'b0, thr_i}) trip_o <= 1'b1;
    end else begin
      cnt_o <= '0;
    end
  end
endmodule

// File: rtl/pcc_trip_logic.sv
module pcc_trip_logic
  import pcc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cfg_block_i,
  input  logic             cfg_rx_inv_i,
  input  logic             cfg_tx_inv_i,
  input  logic [CNT_W-1:0] cfg_thr_i,
  input  logic             cur_pos_i,
  input  logic             rx_raw_i,
  input  logic             det_low_i,
  input  logic             det_high_i,
  output logic             tx_key_o,
  output logic             trip_o
);
  pcc_cfg_t         cfg_live;
  pcc_cfg_t         cfg_q;
  logic [CNT_W-1:0] thr_q;
  logic [PCC_FIELD_BITS-1:0] field_async;
  logic [PCC_FIELD_BITS-1:0] field_sync;
  logic             pos_s, rx_s, low_s, hi_s;
  logic             qual_w, key_lvl_w;
  logic [CNT_W-1:0] cnt_w;
  logic             tx_key_q;

  assign cfg_live.mode   = cfg_block_i ? PCC_MODE_BLOCK : PCC_MODE_PERMIT;
  assign cfg_live.rx_inv = cfg_rx_inv_i;
  assign cfg_live.tx_inv = cfg_tx_inv_i;

  pcc_cfg_reg #(.CNT_W(CNT_W)) cfg_i (
    .clk_i(clk_i), .rst_i(rst_i), .cfg_i(cfg_live), .thr_i(cfg_thr_i),
    .cfg_o(cfg_q), .thr_o(thr_q)
  );

  assign field_async = {det_high_i, det_low_i, rx_raw_i, cur_pos_i};

  pcc_sync #(.WIDTH(PCC_FIELD_BITS), .STAGES(PCC_SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(field_async), .sync_o(field_sync)
  );

  assign {hi_s, low_s, rx_s, pos_s} = field_sync;

  pcc_comparer cmp_i (
    .cfg_i(cfg_q), .pos_i(pos_s), .rx_i(rx_s), .low_i(low_s), .high_i(hi_s),
    .qual_o(qual_w), .key_lvl_o(key_lvl_w)
  );

  pcc_integrator #(.CNT_W(CNT_W)) integ_i (
    .clk_i(clk_i), .rst_i(rst_i), .qual_i(qual_w), .thr_i(thr_q),
    .cnt_o(cnt_w), .trip_o(trip_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) tx_key_q <= cfg_tx_inv_i;
    else       tx_key_q <= key_lvl_w;
  end

  assign tx_key_o = tx_key_q;
endmodule

module pcc_trip_logic_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             trip_o,
  input logic             tx_key_o,
  input logic             qual,
  input logic             pos_s,
  input logic             low_s,
  input logic             hi_s,
  input logic             tx_inv_q,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       cfg_q
);
  a_r8_trip_latched: assert property (@(posedge clk_i) disable iff (rst_i)
    trip_o |=> trip_o);

  a_r6_trip_needs_high: assert property (@(posedge clk_i) disable iff (rst_i)
    (!trip_o && !hi_s) |=> !trip_o);

  a_r7_trip_needs_qual: assert property (@(posedge clk_i) disable iff (rst_i)
    (!trip_o && !qual) |=> !trip_o);

  a_r7_count_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    !qual |=> (cnt == '0));

  a_r5_key_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (tx_key_o == ($past(pos_s && low_s) ^ tx_inv_q)));

  a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> $stable(cfg_q));
endmodule

bind pcc_trip_logic pcc_trip_logic_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .trip_o(trip_o), .tx_key_o(tx_key_o),
  .qual(qual_w), .pos_s(pos_s), .low_s(low_s), .hi_s(hi_s),
  .tx_inv_q(cfg_q.tx_inv), .cnt(cnt_w), .cfg_q(cfg_q)
);

// File: tb/pcc_trip_logic_tb_top.sv
module pcc_trip_logic_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_block = 1'b0, cfg_rx_inv = 1'b0, cfg_tx_inv = 1'b0;
  logic [CNT_W-1:0] cfg_thr = 8'd4;
  logic cur_pos = 1'b0, rx_raw = 1'b0, det_low = 1'b0, det_high = 1'b0;
  logic tx_key, trip;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcc_trip_logic #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .cfg_block_i(cfg_block), .cfg_rx_inv_i(cfg_rx_inv),
    .cfg_tx_inv_i(cfg_tx_inv), .cfg_thr_i(cfg_thr), .cur_pos_i(cur_pos),
    .rx_raw_i(rx_raw), .det_low_i(det_low), .det_high_i(det_high),
    .tx_key_o(tx_key), .trip_o(trip)
  );

  // {block, rx_inv, tx_inv, pos, rx, low, high, exp_tx, exp_trip}
  localparam logic [8:0] VEC [14] = '{
    9'b000_1111_1_1,  // R1 permit hit
    9'b000_1011_1_0,  // R1 no receive
    9'b000_0111_0_0,  // R1 negative half
    9'b000_1110_1_0,  // R6 low only
    9'b000_1101_0_1,  // R6 high alone trips
    9'b100_1011_1_1,  // R2 block, nothing received
    9'b100_1111_1_0,  // R2 block, received
    9'b100_0011_0_0,  // R2 negative half
    9'b010_1011_1_1,  // R3 inverted rx present
    9'b010_1111_1_0,  // R3 inverted rx absent
    9'b110_1111_1_1,  // R3 block with inversion
    9'b001_1111_0_1,  // R4 keyed low
    9'b001_0010_1_0,  // R4 idle high
    9'b100_1010_1_0   // R6 block, low only
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic blk, input logic rxi, input logic txi,
                          input logic [CNT_W-1:0] thr);
    @(negedge clk);
    rst = 1'b1; cfg_block = blk; cfg_rx_inv = rxi; cfg_tx_inv = txi; cfg_thr = thr;
    cur_pos = 0; rx_raw = 0; det_low = 0; det_high = 0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic drive(input logic p, input logic r, input logic l, input logic h);
    cur_pos = p; rx_raw = r; det_low = l; det_high = h;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 reset state, both transmitter polarities
    do_reset(1'b0, 1'b0, 1'b1, 8'd4);
    rst = 1'b1; step(1);
    check("R10 trip in reset", trip, 1'b0);
    check("R10 tx idle inverted", tx_key, 1'b1);
    do_reset(1'b0, 1'b0, 1'b0, 8'd4);
    rst = 1'b1; step(1);
    check("R10 tx idle normal", tx_key, 1'b0);

    foreach (VEC[i]) begin
      do_reset(VEC[i][8], VEC[i][7], VEC[i][6], 8'd4);
      drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      step(8);
      check($sformatf("vector %0d tx R4 R5", i), tx_key, VEC[i][1]);
      check($sformatf("vector %0d trip R1 R2 R3 R6", i), trip, VEC[i][0]);
    end

    // R5 keying latency of three edges
    do_reset(1'b0, 1'b0, 1'b0, 8'd4);
    drive(1, 0, 1, 0);
    step(2);
    check("R5 tx before third edge", tx_key, 1'b0);
    step(1);
    check("R5 tx after third edge", tx_key, 1'b1);

    // R7 exact timing, N=5
    do_reset(1'b0, 1'b0, 1'b0, 8'd5);
    drive(1, 1, 1, 1);
    step(6);
    check("R7 no trip at N+1", trip, 1'b0);
    step(1);
    check("R7 trip at N+2", trip, 1'b1);

    // R8 latched after inputs drop, cleared by reset
    drive(0, 0, 0, 0);
    step(8);
    check("R8 trip latched", trip, 1'b1);
    rst = 1'b1; step(1);
    check("R8 reset clears trip", trip, 1'b0);

    // R7 interruption one short of threshold, N=4
    do_reset(1'b0, 1'b0, 1'b0, 8'd4);
    drive(1, 1, 1, 1);
    step(3);
    drive(0, 1, 1, 1);
    step(1);
    drive(1, 1, 1, 1);
    step(5);
    check("R7 count restarts after gap", trip, 1'b0);
    step(1);
    check("R7 trip after full recount", trip, 1'b1);

    // R7 threshold 0 behaves as 1
    do_reset(1'b0, 1'b0, 1'b0, 8'd0);
    drive(1, 1, 1, 1);
    step(2);
    check("R7 thr0 not before edge 3", trip, 1'b0);
    step(1);
    check("R7 thr0 trips at edge 3", trip, 1'b1);

    // R9 configuration changes after reset are ignored
    do_reset(1'b0, 1'b0, 1'b0, 8'd4);
    cfg_block = 1'b1; cfg_rx_inv = 1'b1; cfg_tx_inv = 1'b1; cfg_thr = 8'd200;
    drive(1, 1, 1, 1);
    step(6);
    check("R9 mode kept permit", trip, 1'b1);
    check("R9 tx polarity kept", tx_key, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule